// File: doc/BRIEF.md
# Wake-up interrupt controller

This block watches 28 asynchronous wake-up pins. Each pin passes through a two-flop synchroniser and then a trigger detector. Each pair of neighbouring pins shares a 4-bit trigger selector, which chooses low level, high level, falling edge, rising edge or both edges. A detected event sets the pin's pending bit. A separate mask bit decides whether that pending bit can reach an interrupt output.

Software reaches the block over a small 32-bit register bus. The bus has a single-cycle write strobe, a word address, write data, and read data that follows the address combinationally. Pending bits are acknowledged by writing ones.

The pins are split into four fixed ranges of 4, 8, 8 and 8. Each range drives its own interrupt output, which is high whenever any unmasked pin in the range is pending.

The block has no state machine. Its only sequencing is the fixed synchroniser and detector pipeline, so there are no states or transitions to list.

Top module: `wake_irq_ctrl`

## Requirements
- R1: A change on a wake-up pin is seen through two synchronising flops. In edge mode, the pending bit reads as set after the third rising clock edge that follows the change, and still reads clear after the second.
- R2: The register map uses these word addresses: 0 is configuration A, 1 is configuration B, 2 is mask, 3 is pending. Pin n below 16 takes its trigger field from configuration A, bits 4*(n/2) to 4*(n/2)+3. Pin n from 16 up takes its field from configuration B, bits 4*((n-16)/2) upward. Bits 24 to 31 of configuration B read as zero.
- R3: Trigger code 4 (rising edge) sets pending on a low-to-high change only.
- R4: Trigger code 2 (falling edge) sets pending on a high-to-low change only.
- R5: Trigger code 6 sets pending on a change in either direction.
- R6: Code 1 (high level) and code 0 (low level) set pending on every cycle while the level is active. A clear written while the level is still active has no lasting effect. A clear written after the level goes inactive leaves the bit at 0.
- R7: Codes 3, 5, 7 and 8 to 15 never set a pending bit.
- R8: A mask bit at 1 keeps its pin away from the outputs but still lets the pin's pending bit be set. Clearing the mask bit lets a bit that is already pending assert its output.
- R9: Writing the pending register clears each bit written as 1. Bits written as 0 keep their value.
- R10: Output 0 covers pins 0 to 3, output 1 covers pins 4 to 11, output 2 covers 12 to 19, and output 3 covers 20 to 27. An output is high only while some pin in its range is both pending and unmasked.
- R11: After reset every mask bit is 1, every pending bit is 0, every trigger field is 0 and all outputs are low.
- R12: Writes to word addresses 4 to 7 change nothing, and reads from them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wake_in | input | 28 | Asynchronous wake-up pins |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_out | output | 4 | One interrupt per pin range |

## Verification
The assertions assume that a bus write lasts exactly one cycle and that reset is applied synchronously with respect to the checked registers. No other assumption is made about the pins, which may toggle at any time. The stimulus changes pins and bus signals only on the falling clock edge. It holds every pin level for at least four cycles, so each change clears the synchroniser before it is checked.

// File: rtl/wake_irq_pkg.sv
package wake_irq_pkg;

    typedef enum logic [3:0] {
        TRIG_LVL_LOW  = 4'd0,
        TRIG_LVL_HIGH = 4'd1,
        TRIG_FALL     = 4'd2,
        TRIG_RISE     = 4'd4,
        TRIG_BOTH     = 4'd6
    } trig_e;

    localparam int unsigned REG_CFG_A = 0;
    localparam int unsigned REG_CFG_B = 1;
    localparam int unsigned REG_MASK  = 2;
    localparam int unsigned REG_PEND  = 3;

    // group index of a pin: a short first range, then equal ranges
    function automatic int unsigned grp_of_line(int unsigned line,
                                                int unsigned first_sz,
                                                int unsigned grp_sz);
        return (line < first_sz) ? 0 : 1 + (line - first_sz) / grp_sz;
    endfunction

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int W = 28
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/wake_line_det.sv
module wake_line_det
    import wake_irq_pkg::*;
#(
    parameter int FLD_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl,
    input  logic [FLD_W-1:0] code,
    output logic             hit
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    always_comb begin
        case (code)
            FLD_W'(TRIG_LVL_LOW):  hit = ~lvl;
            FLD_W'(TRIG_LVL_HIGH): hit = lvl;
            FLD_W'(TRIG_FALL):     hit = prev_q & ~lvl;
            FLD_W'(TRIG_RISE):     hit = ~prev_q & lvl;
            FLD_W'(TRIG_BOTH):     hit = prev_q ^ lvl;
            default:               hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/wake_irq_ctrl.sv
module wake_irq_ctrl
    import wake_irq_pkg::*;
#(
    parameter int NUM_LINES = 28,
    parameter int FIRST_GRP = 4,
    parameter int GRP_SIZE  = 8,
    parameter int NUM_GRPS  = 1 + (NUM_LINES - FIRST_GRP) / GRP_SIZE,
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] wake_in,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_GRPS-1:0]  irq_out
);
    localparam int FLD_W    = 4;
    localparam int NUM_FLDS = NUM_LINES / 2;
    localparam int FPW      = DATA_W / FLD_W;

    logic [NUM_LINES-1:0]      wake_s;
    logic [NUM_LINES-1:0]      hit;
    logic [NUM_FLDS*FLD_W-1:0] trig_q;
    logic [NUM_LINES-1:0]      mask_q;
    logic [NUM_LINES-1:0]      pend_q;
    logic [NUM_LINES-1:0]      clr;

    wake_sync #(.W(NUM_LINES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (wake_in),
        .q     (wake_s)
    );

    // one detector per pin, the pair shares a field
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_det
        wake_line_det #(.FLD_W(FLD_W)) u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .lvl   (wake_s[n]),
            .code  (trig_q[(n/2)*FLD_W +: FLD_W]),
            .hit   (hit[n])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q <= '0;
        end else if (bus_wr) begin
            for (int f = 0; f < NUM_FLDS; f++) begin
                if (bus_addr == ADDR_W'(REG_CFG_A + f / FPW))
                    trig_q[f*FLD_W +: FLD_W] <= bus_wdata[(f % FPW)*FLD_W +: FLD_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mask_q <= '1;
        else if (bus_wr && bus_addr == ADDR_W'(REG_MASK))
            mask_q <= bus_wdata[NUM_LINES-1:0];
    end

    assign clr = (bus_wr && bus_addr == ADDR_W'(REG_PEND)) ?
                 bus_wdata[NUM_LINES-1:0] : '0;

    // a new event in the same cycle wins over the acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr) | hit;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(REG_MASK)) begin
            bus_rdata[NUM_LINES-1:0] = mask_q;
        end else if (bus_addr == ADDR_W'(REG_PEND)) begin
            bus_rdata[NUM_LINES-1:0] = pend_q;
        end else begin
            for (int f = 0; f < NUM_FLDS; f++) begin
                if (bus_addr == ADDR_W'(REG_CFG_A + f / FPW))
                    bus_rdata[(f % FPW)*FLD_W +: FLD_W] = trig_q[f*FLD_W +: FLD_W];
            end
        end
    end

    function automatic logic [NUM_LINES-1:0] grp_mask(int unsigned g);
        logic [NUM_LINES-1:0] m;
        m = '0;
        for (int unsigned n = 0; n < NUM_LINES; n++)
            if (grp_of_line(n, FIRST_GRP, GRP_SIZE) == g) m[n] = 1'b1;
        return m;
    endfunction

    for (genvar g = 0; g < NUM_GRPS; g++) begin : g_out
        localparam logic [NUM_LINES-1:0] GM = grp_mask(g);
        assign irq_out[g] = |(pend_q & ~mask_q & GM);
    end
endmodule

// File: rtl/wake_irq_ctrl_chk.sv
module wake_irq_ctrl_chk
    import wake_irq_pkg::*;
#(
    parameter int NUM_LINES = 28,
    parameter int NUM_GRPS  = 4,
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_wdata,
    input logic [NUM_GRPS-1:0]  irq_out,
    input logic [NUM_LINES-1:0] pend_q,
    input logic [NUM_LINES-1:0] mask_q
);
    a_r8_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(REG_MASK)) |=> mask_q == $past(bus_wdata[NUM_LINES-1:0]));

    a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_W'(REG_MASK)) |=> $stable(mask_q));

    a_r9_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(REG_PEND)) |=>
        ((($past(pend_q) & ~$past(bus_wdata[NUM_LINES-1:0])) & ~pend_q) == '0));

    a_r10_quiet_when_none: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~mask_q) == '0) |-> irq_out == '0);

    a_r10_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> irq_out == '0);
endmodule

bind wake_irq_ctrl wake_irq_ctrl_chk #(
    .NUM_LINES (NUM_LINES),
    .NUM_GRPS  (NUM_GRPS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_out   (irq_out),
    .pend_q    (pend_q),
    .mask_q    (mask_q)
);

// File: tb/wake_irq_ctrl_tb.sv
module wake_irq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] wake_in = '0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_out;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    wake_irq_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake_in   (wake_in),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    // {pin[4:0], code[3:0], start, end, expected pending}
    localparam int NV = 14;
    localparam logic [11:0] VECS [NV] = '{
        {5'd0,  4'd4,  1'b0, 1'b1, 1'b1},
        {5'd3,  4'd4,  1'b1, 1'b0, 1'b0},
        {5'd9,  4'd2,  1'b1, 1'b0, 1'b1},
        {5'd15, 4'd2,  1'b0, 1'b1, 1'b0},
        {5'd16, 4'd6,  1'b0, 1'b1, 1'b1},
        {5'd19, 4'd6,  1'b1, 1'b0, 1'b1},
        {5'd22, 4'd1,  1'b0, 1'b1, 1'b1},
        {5'd27, 4'd1,  1'b0, 1'b0, 1'b0},
        {5'd8,  4'd0,  1'b1, 1'b0, 1'b1},
        {5'd25, 4'd0,  1'b1, 1'b1, 1'b0},
        {5'd2,  4'd3,  1'b0, 1'b1, 1'b0},
        {5'd17, 4'd5,  1'b1, 1'b0, 1'b0},
        {5'd26, 4'd7,  1'b0, 1'b1, 1'b0},
        {5'd11, 4'd15, 1'b1, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'd4:       return "R3";
            4'd2:       return "R4";
            4'd6:       return "R5";
            4'd0, 4'd1: return "R6";
            default:    return "R7";
        endcase
    endfunction

    function automatic int grp_of(input int n);
        return (n < 4) ? 0 : 1 + (n - 4) / 8;
    endfunction

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end

    initial begin
        logic [31:0] r;
        int          ln;
        logic [3:0]  cd;
        logic [31:0] w;

        // R11: reset values, read before any clock edge after release
        idle(3);
        rst_n = 1'b1;
        bus_addr = 3'd2; #1 check("R11 mask", bus_rdata, 32'h0FFF_FFFF);
        bus_addr = 3'd3; #1 check("R11 pend", bus_rdata, 32'h0);
        bus_addr = 3'd0; #1 check("R11 cfgA", bus_rdata, 32'h0);
        bus_addr = 3'd1; #1 check("R11 cfgB", bus_rdata, 32'h0);
        check("R11 irq", {28'h0, irq_out}, 32'h0);

        // R2: layout and read-back of both configuration words
        wr(3'd0, 32'h1234_5678);
        rd(3'd0, r); check("R2 cfgA", r, 32'h1234_5678);
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, r); check("R2 cfgB", r, 32'h00FF_FFFF);

        // R12: unmapped word is ignored
        wr(3'd5, 32'h0);
        rd(3'd2, r); check("R12 mask kept", r, 32'h0FFF_FFFF);
        rd(3'd5, r); check("R12 read zero", r, 32'h0);

        // trigger table, R2 placement plus R3..R7
        for (int v = 0; v < NV; v++) begin
            ln = int'(VECS[v][11:7]);
            cd = VECS[v][6:3];
            wr(3'd0, 32'h3333_3333);
            wr(3'd1, 32'h3333_3333);
            w = 32'h3333_3333;
            w[((ln % 16) / 2) * 4 +: 4] = cd;
            wr((ln >= 16) ? 3'd1 : 3'd0, w);
            wake_in[ln] = VECS[v][2];
            idle(4);
            wr(3'd3, 32'h0FFF_FFFF);
            wake_in[ln] = VECS[v][1];
            idle(4);
            rd(3'd3, r);
            check(req_of(cd), {31'h0, r[ln]}, {31'h0, VECS[v][0]});
        end

        // R1: latency through synchroniser
        wake_in = '0;
        wr(3'd0, 32'h4444_4444);
        wr(3'd1, 32'h4444_4444);
        idle(4);
        wr(3'd3, 32'h0FFF_FFFF);
        @(negedge clk) wake_in[5] = 1'b1;
        @(negedge clk); @(negedge clk);
        #1 check("R1 after two edges", {31'h0, bus_rdata[5]}, 32'h0);
        @(negedge clk);
        #1 check("R1 after three edges", {31'h0, bus_rdata[5]}, 32'h1);
        wake_in[5] = 1'b0;
        idle(4);

        // R10: each pin reaches exactly its own output
        wr(3'd2, 32'h0);
        for (int n = 0; n < 28; n++) begin
            wr(3'd3, 32'h0FFF_FFFF);
            #1 check("R10 idle", {28'h0, irq_out}, 32'h0);
            wake_in[n] = 1'b1;
            idle(4);
            check("R10 range", {28'h0, irq_out}, 32'h1 << grp_of(n));
            wake_in[n] = 1'b0;
            idle(4);
        end

        // R8: masked pin still records, unmasking exposes it
        wr(3'd2, 32'h0FFF_FFFF);
        wr(3'd3, 32'h0FFF_FFFF);
        wake_in[13] = 1'b1;
        wake_in[20] = 1'b1;
        idle(4);
        rd(3'd3, r); check("R8 recorded", r, 32'h0010_2000);
        check("R8 masked", {28'h0, irq_out}, 32'h0);
        wr(3'd2, 32'h0FFF_DFFF);
        #1 check("R8 unmasked", {28'h0, irq_out}, 32'h4);

        // R9: write-one-to-clear
        wr(3'd3, 32'h0);
        rd(3'd3, r); check("R9 zero write", r, 32'h0010_2000);
        wr(3'd3, 32'h0000_2000);
        rd(3'd3, r); check("R9 one write", r, 32'h0010_0000);
        check("R9 irq drops", {28'h0, irq_out}, 32'h0);

        // R6: level clear sticks only once inactive
        wr(3'd0, 32'h4444_1444);
        wake_in[6] = 1'b1;
        idle(4);
        wr(3'd3, 32'h0000_0040);
        rd(3'd3, r); check("R6 clear while active", {31'h0, r[6]}, 32'h1);
        wake_in[6] = 1'b0;
        idle(4);
        wr(3'd3, 32'h0000_0040);
        idle(2);
        rd(3'd3, r); check("R6 clear when inactive", {31'h0, r[6]}, 32'h0);

        report();
    end
endmodule